// File: doc/BRIEF.md
# Trigger-Linked Timer Counter

A 16-bit up-counter with a clock prescaler and a programmable period. A slave controller decides what advances the counter. In the plain mode the counter runs freely while it is enabled. In the other modes one selected external trigger line can hold it, start it, restart it, or clock it. A master selector drives a single trigger output from one internal event, so the timer can pace a converter or another timer. Four compare channels each give a level output that is high while the count is below that channel's compare value.

Software reaches the block through a single-word write/read port. A write takes effect at the clock edge on which `wr_en` is high. The read data is registered, so it shows the word addressed in the previous cycle. The prescaler value is always held in a buffer and reaches the counter only on an update event. The period value can be buffered the same way or applied at once. An update event is a period wrap, a software update request, or a restart edge. Every update event sets a sticky flag, which can raise an interrupt.

Top module: `trig_timer`

## Requirements
- R1: After synchronous reset the following values hold. The counter, prescaler and compare values are 0. The period reads 0xFFFF. All mode fields are 0. `trgo`, `irq` and `cmp_ref` are low.
- R2: The word addresses are:
  - 0: control. Bit 0 is run, bit 1 is period buffering.
  - 1: output-mode select, in bits 6:4.
  - 2: slave control. Bits 2:0 are the slave mode and bits 6:4 are the trigger source.
  - 3: interrupt enable, in bit 0.
  - 4: status. Bit 0 is the update flag.
  - 5: event. Writing 1 to bit 0 requests an update.
  - 6: counter.
  - 7: prescaler.
  - 8: period.
  - 9 to 12: compare values 0 to 3.

  `rdata` returns the addressed word one clock after the address is presented.
- R3: Slave mode 0 is free running, and codes 1 to 3 act the same way. While run is set, the counter advances once every prescaler+1 clocks. When it advances from a value at or above the period, it goes to 0 and raises an update event instead of counting up.
- R4: Writing 1 to event bit 0 does four things: it zeroes the counter and the prescaler divider, loads the buffered prescaler and period, and raises an update event.
- R5: When control bit 1 is clear, a written period takes effect at once. When it is set, a written period waits for the next update event. A written prescaler always waits for an update event.
- R6: Each update event sets status bit 0. Writing status with bit 0 = 0 clears the flag. Writing 1 leaves it unchanged. `irq` is high exactly when the flag and the enable bit are both set.
- R7: Slave mode 4 (restart). A rising edge on the selected trigger zeroes the counter and the divider and raises an update event. This happens even while run is clear.
- R8: Slave mode 5 (gated). The counter advances only while the selected trigger is high. While the trigger is low it holds its value and is not cleared.
- R9: Slave mode 6 (start). A rising edge on the selected trigger sets the run bit. The count is kept, not cleared.
- R10: Slave mode 7 (external clock). With run set, each rising edge of the selected trigger is one prescaler input tick, so prescaler+1 edges make one count.
- R11: Each trigger line passes through two synchronising flip-flops. Only the line chosen by the source field has any effect. In gated mode, the number of counts equals the number of clock edges for which the selected line was held high.
- R12: Output modes 0, 1 and 2 drive `trgo` as follows:
  - Mode 0: a one-cycle pulse after each software update request.
  - Mode 1: the run bit.
  - Mode 2: a one-cycle pulse after each update event.
- R13: In output mode 3, `trgo` gives a one-cycle pulse each time the counter advances into the value held in compare 0.
- R14: `cmp_ref[i]` is high while counter < compare i. Output modes 4 to 7 drive `trgo` from `cmp_ref[0]` to `cmp_ref[3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| trig_in | input | N_TRIG | Asynchronous trigger lines |
| trgo | output | 1 | Selected trigger output |
| irq | output | 1 | Update interrupt |
| cmp_ref | output | N_CH | Compare reference levels |

## Verification
The properties assume a few things about the inputs:
- A counter write, an update request, or a restart edge may change the count arbitrarily. The hold and step properties therefore exclude those cycles.
- The trigger source field is not changed while a line that matters is high, because a change of source can produce an edge.

The stimulus follows these rules:
- It changes the source and slave mode only while every trigger line is low.
- It holds each trigger level for at least two clocks, so the synchroniser sees every edge.
- It reads the counter only while the counter is stopped or its gate is closed.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_SLAVE  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_IE     = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EVGEN  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_PRESC  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CMP0   = 4'd9;

  localparam int MM_LSB = 4;  // output-mode field
  localparam int TS_LSB = 4;  // trigger source field

  typedef enum logic [2:0] {
    SLV_OFF    = 3'd0,
    SLV_ENC1   = 3'd1,
    SLV_ENC2   = 3'd2,
    SLV_ENC3   = 3'd3,
    SLV_RESET  = 3'd4,
    SLV_GATED  = 3'd5,
    SLV_START  = 3'd6,
    SLV_EXTCLK = 3'd7
  } slave_mode_e;

  typedef enum logic [2:0] {
    MST_SWUPD    = 3'd0,
    MST_ENABLE   = 3'd1,
    MST_UPDATE   = 3'd2,
    MST_CMPPULSE = 3'd3,
    MST_REF0     = 3'd4,
    MST_REF1     = 3'd5,
    MST_REF2     = 3'd6,
    MST_REF3     = 3'd7
  } master_mode_e;
endpackage

// File: rtl/trig_timer_sync.sv
module trig_timer_sync #(
  parameter int N_TRIG = 8,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]  sel,
  output logic              trig_lvl,
  output logic              trig_rise
);
  logic [N_TRIG-1:0] meta_q, sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= trig_in;
      sync_q <= meta_q;
      prev_q <= sync_q[sel];
    end
  end

  assign trig_lvl  = sync_q[sel];
  assign trig_rise = sync_q[sel] & ~prev_q;
endmodule

// File: rtl/trig_timer_core.sv
module trig_timer_core
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             preload,
  input  slave_mode_e      smode,
  input  logic             trig_lvl,
  input  logic             trig_rise,
  input  logic             ug,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] psc_pre,
  input  logic [CNT_W-1:0] arr_pre,
  input  logic [CNT_W-1:0] cmp_first,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] psc_act,
  output logic             upd_evt,
  output logic             cmp_evt,
  output logic             start_req
);
  logic [CNT_W-1:0] pcnt_q, arr_sh_q, arr_act, cnt_nxt;
  logic             tick, step, wrap, restart;

  // encoder codes fall back to free running
  always_comb begin
    case (smode)
      SLV_GATED:  tick = run & trig_lvl;
      SLV_EXTCLK: tick = run & trig_rise;
      default:    tick = run;
    endcase
  end

  assign arr_act   = preload ? arr_sh_q : arr_pre;
  assign restart   = ug | ((smode == SLV_RESET) & trig_rise);
  assign step      = tick & (pcnt_q >= psc_act);
  assign wrap      = step & (cnt_q >= arr_act);
  assign cnt_nxt   = wrap ? '0 : cnt_q + 1'b1;
  assign upd_evt   = restart | wrap;
  assign cmp_evt   = step & ~restart & (cnt_nxt == cmp_first);
  assign start_req = (smode == SLV_START) & trig_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      pcnt_q   <= '0;
      psc_act  <= '0;
      arr_sh_q <= '1;
    end else begin
      if (restart) begin
        cnt_q  <= '0;
        pcnt_q <= '0;
      end else begin
        if (cnt_wr)    cnt_q <= cnt_wdata;
        else if (step) cnt_q <= cnt_nxt;
        if (tick)      pcnt_q <= step ? '0 : pcnt_q + 1'b1;
      end
      if (upd_evt) begin
        psc_act  <= psc_pre;
        arr_sh_q <= arr_pre;
      end
    end
  end
endmodule

// File: rtl/trig_timer_out.sv
module trig_timer_out
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp,
  input  master_mode_e               mmode,
  input  logic                       run,
  input  logic                       ug,
  input  logic                       upd_evt,
  input  logic                       cmp_evt,
  output logic [N_CH-1:0]            cmp_ref,
  output logic                       trgo
);
  logic ug_q, upd_q, cmpp_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ref
    assign cmp_ref[ch] = cnt < cmp[ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ug_q   <= 1'b0;
      upd_q  <= 1'b0;
      cmpp_q <= 1'b0;
    end else begin
      ug_q   <= ug;
      upd_q  <= upd_evt;
      cmpp_q <= cmp_evt;
    end
  end

  always_comb begin
    case (mmode)
      MST_SWUPD:    trgo = ug_q;
      MST_ENABLE:   trgo = run;
      MST_UPDATE:   trgo = upd_q;
      MST_CMPPULSE: trgo = cmpp_q;
      default:      trgo = cmp_ref[mmode[1:0]];
    endcase
  end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_TRIG = 8,
  parameter int N_CH   = 4,
  localparam int SEL_W = $clog2(N_TRIG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CNT_W-1:0]    wdata,
  output logic [CNT_W-1:0]    rdata,
  input  logic [N_TRIG-1:0]   trig_in,
  output logic                trgo,
  output logic                irq,
  output logic [N_CH-1:0]     cmp_ref
);
  logic                       run_q, preload_q, uie_q, uif_q;
  master_mode_e               mm_q;
  slave_mode_e                smode_q;
  logic [SEL_W-1:0]           tsel_q;
  logic [CNT_W-1:0]           psc_pre_q, arr_pre_q, cnt_q, psc_act, rd_mux;
  logic [N_CH-1:0][CNT_W-1:0] cmp_q;
  logic                       trig_lvl, trig_rise, upd_evt, cmp_evt, start_req;
  logic                       ug, cnt_wr;

  assign ug     = wr_en && (addr == ADR_EVGEN) && wdata[0];
  assign cnt_wr = wr_en && (addr == ADR_COUNT);

  trig_timer_sync #(.N_TRIG(N_TRIG)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .sel(tsel_q),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise)
  );

  trig_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run_q), .preload(preload_q), .smode(smode_q),
    .trig_lvl(trig_lvl), .trig_rise(trig_rise), .ug(ug), .cnt_wr(cnt_wr),
    .cnt_wdata(wdata), .psc_pre(psc_pre_q), .arr_pre(arr_pre_q),
    .cmp_first(cmp_q[0]), .cnt_q(cnt_q), .psc_act(psc_act),
    .upd_evt(upd_evt), .cmp_evt(cmp_evt), .start_req(start_req)
  );

  trig_timer_out #(.CNT_W(CNT_W), .N_CH(N_CH)) u_out (
    .clk(clk), .rst(rst), .cnt(cnt_q), .cmp(cmp_q), .mmode(mm_q), .run(run_q),
    .ug(ug), .upd_evt(upd_evt), .cmp_evt(cmp_evt), .cmp_ref(cmp_ref), .trgo(trgo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      preload_q <= 1'b0;
      mm_q      <= MST_SWUPD;
      smode_q   <= SLV_OFF;
      tsel_q    <= '0;
      uie_q     <= 1'b0;
      uif_q     <= 1'b0;
      psc_pre_q <= '0;
      arr_pre_q <= '1;
    end else begin
      if (start_req) run_q <= 1'b1;
      else if (wr_en && addr == ADR_CTRL) run_q <= wdata[0];
      if (wr_en && addr == ADR_CTRL) preload_q <= wdata[1];
      if (wr_en && addr == ADR_MODE) mm_q <= master_mode_e'(wdata[MM_LSB +: 3]);
      if (wr_en && addr == ADR_SLAVE) begin
        smode_q <= slave_mode_e'(wdata[2:0]);
        tsel_q  <= wdata[TS_LSB +: SEL_W];
      end
      if (wr_en && addr == ADR_IE) uie_q <= wdata[0];
      if (upd_evt) uif_q <= 1'b1;
      else if (wr_en && addr == ADR_STATUS && !wdata[0]) uif_q <= 1'b0;
      if (wr_en && addr == ADR_PRESC)  psc_pre_q <= wdata;
      if (wr_en && addr == ADR_RELOAD) arr_pre_q <= wdata;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst) cmp_q[ch] <= '0;
      else if (wr_en && addr == ADDR_W'(int'(ADR_CMP0) + ch)) cmp_q[ch] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_CTRL:   rd_mux[1:0] = {preload_q, run_q};
      ADR_MODE:   rd_mux[MM_LSB +: 3] = mm_q;
      ADR_SLAVE:  begin
        rd_mux[2:0] = smode_q;
        rd_mux[TS_LSB +: SEL_W] = tsel_q;
      end
      ADR_IE:     rd_mux[0] = uie_q;
      ADR_STATUS: rd_mux[0] = uif_q;
      ADR_COUNT:  rd_mux = cnt_q;
      ADR_PRESC:  rd_mux = psc_pre_q;
      ADR_RELOAD: rd_mux = arr_pre_q;
      default: begin
        for (int c = 0; c < N_CH; c++)
          if (addr == ADDR_W'(int'(ADR_CMP0) + c)) rd_mux = cmp_q[c];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign irq = uif_q & uie_q;
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk
  import trig_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  psc_act,
  input slave_mode_e       smode,
  input logic              trig_lvl,
  input logic              trig_rise,
  input logic              upd_evt,
  input logic              run,
  input logic              uif
);
  logic sw_cnt, sw_ug, sw_clr;
  assign sw_cnt = wr_en && (addr == ADR_COUNT);
  assign sw_ug  = wr_en && (addr == ADR_EVGEN) && wdata[0];
  assign sw_clr = wr_en && (addr == ADR_STATUS) && !wdata[0];

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt) && !$past(sw_cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

  p_shadow_on_update_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(psc_act) |-> $past(upd_evt));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (uif && !sw_clr) |=> uif);

  p_restart_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (smode == SLV_RESET && trig_rise) |=> (cnt == '0 && uif));

  p_gated_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (smode == SLV_GATED && !trig_lvl && !sw_cnt && !sw_ug) |=> $stable(cnt));

  p_start_sets_run_r9: assert property (@(posedge clk) disable iff (rst)
    (smode == SLV_START && trig_rise) |=> run);

  p_extclk_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (smode == SLV_EXTCLK && !trig_rise && !sw_cnt && !sw_ug) |=> $stable(cnt));
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt_q), .psc_act(psc_act), .smode(smode_q), .trig_lvl(trig_lvl),
  .trig_rise(trig_rise), .upd_evt(upd_evt), .run(run_q), .uif(uif_q)
);

// File: tb/tb_trig_timer.sv
`timescale 1ns/1ps
module tb_trig_timer;
  import trig_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  trig_in = '0;
  logic        trgo, irq;
  logic [3:0]  cmp_ref;

  int n_cmp = 0;
  int n_bad = 0;
  int hi    = 0;
  logic [15:0] d;

  // {prescaler, period, ticks, expected count, expected flag}
  localparam int VEC [6][5] = '{
    '{0, 9,     7,   7,   0},
    '{0, 9,     10,  0,   1},
    '{1, 9,     7,   3,   0},
    '{3, 4,     24,  1,   1},
    '{2, 0,     5,   0,   1},
    '{0, 65535, 100, 100, 0}
  };

  trig_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_in(trig_in), .trgo(trgo), .irq(irq), .cmp_ref(cmp_ref)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (trgo === 1'b1) hi++;

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic run(int n, logic [15:0] base);
    wr(ADR_CTRL, base | 16'h1);
    repeat (n - 1) @(negedge clk);
    wr(ADR_CTRL, base);
  endtask

  task automatic pulse(int idx, int h, int l);
    trig_in[idx] = 1'b1;
    repeat (h) @(negedge clk);
    trig_in[idx] = 1'b0;
    repeat (l) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(ADR_COUNT, d);  chk("R1 count", d, 0);
    rd(ADR_RELOAD, d); chk("R1 period", d, 65535);
    chk("R1 trgo", trgo, 0);
    chk("R1 irq", irq, 0);
    chk("R1 cmp_ref", cmp_ref, 0);

    // R3 free-running vectors
    for (int v = 0; v < 6; v++) begin
      wr(ADR_PRESC, 16'(VEC[v][0]));
      wr(ADR_RELOAD, 16'(VEC[v][1]));
      wr(ADR_EVGEN, 16'h1);
      wr(ADR_STATUS, 16'h0);
      run(VEC[v][2], 16'h0);
      rd(ADR_COUNT, d);  chk($sformatf("R3 count row %0d", v), d, VEC[v][3]);
      rd(ADR_STATUS, d); chk($sformatf("R3 flag row %0d", v), d[0], VEC[v][4]);
    end

    // R4 / R5 update request and period buffering
    wr(ADR_PRESC, 16'h0);
    wr(ADR_RELOAD, 16'd9);
    wr(ADR_CTRL, 16'h2);
    wr(ADR_EVGEN, 16'h1);
    rd(ADR_COUNT, d); chk("R4 update zeroes count", d, 0);
    wr(ADR_RELOAD, 16'd3);
    wr(ADR_STATUS, 16'h0);
    run(6, 16'h2);
    rd(ADR_COUNT, d); chk("R5 buffered period held", d, 6);
    wr(ADR_EVGEN, 16'h1);
    rd(ADR_STATUS, d); chk("R4 update sets flag", d[0], 1);
    run(5, 16'h2);
    rd(ADR_COUNT, d); chk("R5 buffered period loaded", d, 1);
    wr(ADR_CTRL, 16'h0);

    // R6 flag and interrupt
    wr(ADR_IE, 16'h1);
    wr(ADR_EVGEN, 16'h1);
    chk("R6 irq set", irq, 1);
    wr(ADR_STATUS, 16'h1);
    chk("R6 write 1 keeps flag", irq, 1);
    wr(ADR_STATUS, 16'h0);
    chk("R6 write 0 clears", irq, 0);
    wr(ADR_EVGEN, 16'h1);
    wr(ADR_IE, 16'h0);
    chk("R6 irq masked", irq, 0);
    rd(ADR_STATUS, d); chk("R6 flag kept while masked", d[0], 1);
    wr(ADR_STATUS, 16'h0);

    // R12 output modes 0..2
    wr(ADR_MODE, 16'h00);
    wr(ADR_EVGEN, 16'h1);
    chk("R12 mode0 pulse high", trgo, 1);
    @(negedge clk);
    chk("R12 mode0 pulse one cycle", trgo, 0);
    wr(ADR_MODE, 16'h10);
    chk("R12 mode1 stopped", trgo, 0);
    wr(ADR_CTRL, 16'h1);
    chk("R12 mode1 running", trgo, 1);
    wr(ADR_CTRL, 16'h0);
    chk("R12 mode1 stopped again", trgo, 0);
    wr(ADR_MODE, 16'h20);
    wr(ADR_RELOAD, 16'd3);
    wr(ADR_EVGEN, 16'h1);
    @(negedge clk);
    hi = 0;
    run(12, 16'h0);
    repeat (2) @(negedge clk);
    chk("R12 mode2 update pulses", hi, 3);

    // R13 compare pulse
    wr(ADR_MODE, 16'h30);
    wr(ADR_CMP0, 16'd2);
    wr(ADR_RELOAD, 16'd4);
    wr(ADR_EVGEN, 16'h1);
    @(negedge clk);
    hi = 0;
    run(10, 16'h0);
    repeat (2) @(negedge clk);
    chk("R13 compare pulses", hi, 2);

    // R14 compare references
    wr(ADR_COUNT, 16'd3);
    wr(ADR_CMP0 + 4'd1, 16'd5);
    wr(ADR_CMP0 + 4'd2, 16'd3);
    wr(ADR_CMP0 + 4'd3, 16'd4);
    chk("R14 cmp_ref levels", cmp_ref, 4'b1010);
    wr(ADR_MODE, 16'h50);
    chk("R14 mode5 follows ref1", trgo, 1);
    wr(ADR_MODE, 16'h60);
    chk("R14 mode6 follows ref2", trgo, 0);
    wr(ADR_MODE, 16'h00);

    // R8 / R11 gated mode, source 2
    wr(ADR_RELOAD, 16'd1000);
    wr(ADR_EVGEN, 16'h1);
    wr(ADR_SLAVE, 16'h0025);
    rd(ADR_SLAVE, d); chk("R2 slave readback", d, 16'h0025);
    wr(ADR_CTRL, 16'h1);
    repeat (10) @(negedge clk);
    rd(ADR_COUNT, d); chk("R8 gate closed holds", d, 0);
    pulse(2, 7, 10);
    rd(ADR_COUNT, d); chk("R8 gated count kept", d, 7);
    pulse(3, 8, 6);
    rd(ADR_COUNT, d); chk("R11 other line ignored", d, 7);
    pulse(2, 5, 6);
    rd(ADR_COUNT, d); chk("R11 counts equal high edges", d, 12);
    wr(ADR_CTRL, 16'h0);

    // R10 external clock, source 1
    wr(ADR_SLAVE, 16'h0017);
    wr(ADR_PRESC, 16'h0);
    wr(ADR_EVGEN, 16'h1);
    wr(ADR_CTRL, 16'h1);
    for (int p = 0; p < 5; p++) pulse(1, 2, 2);
    repeat (4) @(negedge clk);
    rd(ADR_COUNT, d); chk("R10 one count per edge", d, 5);
    wr(ADR_PRESC, 16'h1);
    wr(ADR_EVGEN, 16'h1);
    for (int p = 0; p < 5; p++) pulse(1, 2, 2);
    repeat (4) @(negedge clk);
    rd(ADR_COUNT, d); chk("R10 prescaled edges", d, 2);
    wr(ADR_CTRL, 16'h0);
    wr(ADR_PRESC, 16'h0);
    wr(ADR_EVGEN, 16'h1);

    // R7 restart mode, stopped
    wr(ADR_SLAVE, 16'h0014);
    wr(ADR_COUNT, 16'd77);
    wr(ADR_STATUS, 16'h0);
    rd(ADR_COUNT, d); chk("R2 counter write", d, 77);
    pulse(1, 3, 4);
    rd(ADR_COUNT, d);  chk("R7 edge clears count", d, 0);
    rd(ADR_STATUS, d); chk("R7 edge sets flag", d[0], 1);

    // R9 start mode
    wr(ADR_SLAVE, 16'h0016);
    wr(ADR_COUNT, 16'd50);
    rd(ADR_CTRL, d); chk("R9 run clear before edge", d[0], 0);
    pulse(1, 3, 4);
    rd(ADR_CTRL, d); chk("R9 edge sets run", d[0], 1);
    wr(ADR_CTRL, 16'h0);
    rd(ADR_COUNT, d); chk("R9 count kept and advanced", d, 56);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule